// File: doc/BRIEF.md
# Diagnostic Threshold Alarm Comparator

This block turns five live monitor readings into the alarm and warning flag bytes of a transceiver diagnostic page. The five readings are module temperature, supply voltage, transmitter bias current, transmitted optical power and received optical power. Each reading is a 16-bit word. Each one has four limits: a high alarm, a low alarm, a high warning and a low warning. The readings arrive as ten bytes and the limits as forty bytes, always with the most significant byte first. Temperature is a signed two's-complement word. The other four readings are unsigned.

When the monitor strobe is seen in the idle state, the block takes a snapshot of all fifty bytes in one cycle. It then visits the five readings in turn, using a single shared comparator. After the last reading it publishes all four flag bytes together and pulses a completion output. Between completions the flag bytes do not move. The controller has three states. IDLE waits for the strobe; the transition IDLE→SCAN captures the snapshot and clears the reading index. SCAN judges one reading per cycle; SCAN→SCAN advances the index, and SCAN→COMMIT is taken after the fifth reading. COMMIT publishes the flags; COMMIT→IDLE always follows one cycle later.

Top module: `diag_threshold_flagger`

## Requirements
- R1: While reset is asserted and after its release, all four flag bytes read 0x00 and `flags_done` is low.
- R2: A high flag is set only when the reading is strictly greater than its high limit. A reading equal to the limit leaves the flag clear.
- R3: A low flag is set only when the reading is strictly less than its low limit. A reading equal to the limit leaves the flag clear.
- R4: Temperature (reading 0) is compared as signed two's complement, so 0xFF00 (−1 °C) is below a high limit of 0x6E00 and above a low limit of 0xD300.
- R5: Readings 1 to 4 are compared as unsigned, so a supply reading of 0xFF00 is above a high limit of 36000.
- R6: In `alarm_flags_a`, bit pairs 7/6, 5/4, 3/2 and 1/0 hold the high/low alarm of temperature, supply, bias and transmitted power respectively.
- R7: In `alarm_flags_b`, bit 7 is the received-power high alarm, bit 6 is the received-power low alarm, and bits 5 to 0 read zero.
- R8: `warn_flags_a` and `warn_flags_b` use the same layout as R6 and R7, but are judged against the warning limits.
- R9: Reading p sits at live bytes 2p (MSB) and 2p+1 (LSB). Its limits sit at limit bytes 8p+0/1 (high alarm), 8p+2/3 (low alarm), 8p+4/5 (high warning) and 8p+6/7 (low warning). Byte k of a bus occupies bits [8k+7:8k].
- R10: The result depends only on the bytes present at the strobe edge. Input changes after that edge do not affect the result.
- R11: If the strobe is sampled at edge E, the flag bytes update and `flags_done` is high for exactly one cycle after edge E+6. The flag bytes hold their value at all other times.
- R12: A strobe that arrives while a judgement is in progress (SCAN or COMMIT) is ignored and produces no extra completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_strobe | input | 1 | Monitor update strobe |
| live_bytes | input | 80 | Ten live reading bytes, byte k at [8k+7:8k] |
| limit_bytes | input | 320 | Forty limit bytes, byte k at [8k+7:8k] |
| alarm_flags_a | output | 8 | First alarm flag byte |
| alarm_flags_b | output | 8 | Second alarm flag byte |
| warn_flags_a | output | 8 | First warning flag byte |
| warn_flags_b | output | 8 | Second warning flag byte |
| flags_done | output | 1 | One-cycle pulse when new flags are published |

## Verification
The bench drives readings exactly equal to each limit. A design that used ≥ or ≤ would raise flags there. It also drives negative temperatures: −1 °C must raise nothing, and −46 °C must raise the low alarm; an unsigned compare would turn both of these into high alarms. An unsigned supply word of 0xFF00 is used as well, and a signed compare would call it low. The bench rewrites the inputs in the middle of a scan and also raises the strobe while the block is busy. A design without a snapshot would then mix old and new readings, and a design that re-triggered would emit a second completion or flags that change early. Limits are set so that swapped MSB/LSB bytes or a wrong bit pair would give a different byte.

// File: rtl/diag_cmp_pkg.sv
package diag_cmp_pkg;

    localparam int DC_PARAMS    = 5;
    localparam int DC_BYTE      = 8;
    localparam int DC_WORD      = 2 * DC_BYTE;
    localparam int DC_LIMITS    = 4;
    localparam int DC_IDX_W     = $clog2(DC_PARAMS);
    localparam int DC_LIVE_BITS = DC_PARAMS * DC_WORD;
    localparam int DC_LIM_BITS  = DC_PARAMS * DC_LIMITS * DC_WORD;
    localparam int DC_LATENCY   = DC_PARAMS + 1;

    // limit slots inside one reading's group, in byte order
    localparam int LIM_HI_ALARM = 0;
    localparam int LIM_LO_ALARM = 1;
    localparam int LIM_HI_WARN  = 2;
    localparam int LIM_LO_WARN  = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_COMMIT = 2'd2
    } dc_state_e;

    typedef struct packed {
        logic hi_alarm;
        logic lo_alarm;
        logic hi_warn;
        logic lo_warn;
    } dc_verdict_t;

    typedef logic [DC_PARAMS-1:0][DC_WORD-1:0]                word_set_t;
    typedef logic [DC_PARAMS-1:0][DC_LIMITS-1:0][DC_WORD-1:0] limit_set_t;

    // Packs per-reading high/low bits into the two flag bytes.
    function automatic logic [2*DC_BYTE-1:0] pack_flag_pair(
        input logic [DC_PARAMS-1:0] hi,
        input logic [DC_PARAMS-1:0] lo
    );
        logic [DC_BYTE-1:0] first;
        logic [DC_BYTE-1:0] second;
        first  = '0;
        second = '0;
        for (int p = 0; p < 4; p++) begin
            first[7-2*p] = hi[p];
            first[6-2*p] = lo[p];
        end
        second[7] = hi[4];
        second[6] = lo[4];
        return {first, second};
    endfunction

endpackage

// File: rtl/diag_snapshot.sv
module diag_snapshot
    import diag_cmp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_en,
    input  logic [DC_LIVE_BITS-1:0] live_bytes,
    input  logic [DC_LIM_BITS-1:0]  limit_bytes,
    output word_set_t               live_w,
    output limit_set_t              limit_w
);

    word_set_t  live_d;
    limit_set_t limit_d;

    // byte 2k is the MSB of word k
    generate
        for (genvar p = 0; p < DC_PARAMS; p++) begin : g_param
            assign live_d[p] = {live_bytes[DC_WORD*p +: DC_BYTE],
                                live_bytes[DC_WORD*p + DC_BYTE +: DC_BYTE]};
            for (genvar k = 0; k < DC_LIMITS; k++) begin : g_limit
                localparam int BASE = DC_WORD * (DC_LIMITS * p + k);
                assign limit_d[p][k] = {limit_bytes[BASE +: DC_BYTE],
                                        limit_bytes[BASE + DC_BYTE +: DC_BYTE]};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_w  <= '0;
            limit_w <= '0;
        end else if (cap_en) begin
            live_w  <= live_d;
            limit_w <= limit_d;
        end
    end

    assert_snapshot_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(live_w) && $stable(limit_w)));

endmodule

// File: rtl/diag_cmp.sv
module diag_cmp
    import diag_cmp_pkg::*;
(
    input  logic                               is_signed,
    input  logic [DC_WORD-1:0]                 value,
    input  logic [DC_LIMITS-1:0][DC_WORD-1:0]  limits,
    output dc_verdict_t                        verdict
);

    function automatic logic above(input logic sgn, input logic [DC_WORD-1:0] a,
                                   input logic [DC_WORD-1:0] b);
        if (sgn) return $signed(a) > $signed(b);
        return a > b;
    endfunction

    always_comb begin
        verdict.hi_alarm = above(is_signed, value, limits[LIM_HI_ALARM]);
        verdict.lo_alarm = above(is_signed, limits[LIM_LO_ALARM], value);
        verdict.hi_warn  = above(is_signed, value, limits[LIM_HI_WARN]);
        verdict.lo_warn  = above(is_signed, limits[LIM_LO_WARN], value);
    end

endmodule

// File: rtl/diag_flag_acc.sv
module diag_flag_acc
    import diag_cmp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DC_IDX_W-1:0] idx,
    input  dc_verdict_t         verdict,
    input  logic                commit,
    output logic [DC_BYTE-1:0]  alarm_a,
    output logic [DC_BYTE-1:0]  alarm_b,
    output logic [DC_BYTE-1:0]  warn_a,
    output logic [DC_BYTE-1:0]  warn_b,
    output logic                done
);

    logic [DC_PARAMS-1:0] ah_q, al_q, wh_q, wl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ah_q <= '0;
            al_q <= '0;
            wh_q <= '0;
            wl_q <= '0;
        end else if (wr_en) begin
            ah_q[idx] <= verdict.hi_alarm;
            al_q[idx] <= verdict.lo_alarm;
            wh_q[idx] <= verdict.hi_warn;
            wl_q[idx] <= verdict.lo_warn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {alarm_a, alarm_b} <= '0;
            {warn_a, warn_b}   <= '0;
            done               <= 1'b0;
        end else begin
            done <= commit;
            if (commit) begin
                {alarm_a, alarm_b} <= pack_flag_pair(ah_q, al_q);
                {warn_a, warn_b}   <= pack_flag_pair(wh_q, wl_q);
            end
        end
    end

    assert_flags_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable({alarm_a, alarm_b, warn_a, warn_b})));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/diag_threshold_flagger.sv
module diag_threshold_flagger
    import diag_cmp_pkg::*;
#(
    parameter logic [DC_PARAMS-1:0] SIGNED_MASK = 5'b00001
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mon_strobe,
    input  logic [DC_LIVE_BITS-1:0] live_bytes,
    input  logic [DC_LIM_BITS-1:0]  limit_bytes,
    output logic [DC_BYTE-1:0]      alarm_flags_a,
    output logic [DC_BYTE-1:0]      alarm_flags_b,
    output logic [DC_BYTE-1:0]      warn_flags_a,
    output logic [DC_BYTE-1:0]      warn_flags_b,
    output logic                    flags_done
);

    localparam logic [DC_IDX_W-1:0] LAST_IDX = DC_IDX_W'(DC_PARAMS - 1);

    dc_state_e           state, state_nx;
    logic [DC_IDX_W-1:0] idx;
    logic                cap_en, scan_we, commit;
    word_set_t           live_w;
    limit_set_t          limit_w;
    dc_verdict_t         verdict;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (mon_strobe)       state_nx = ST_SCAN;
            ST_SCAN:   if (idx == LAST_IDX)  state_nx = ST_COMMIT;
            ST_COMMIT:                       state_nx = ST_IDLE;
            default:                         state_nx = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        cap_en  = 1'b0;
        scan_we = 1'b0;
        commit  = 1'b0;
        unique case (state)
            ST_IDLE:   cap_en  = mon_strobe;
            ST_SCAN:   scan_we = 1'b1;
            ST_COMMIT: commit  = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (cap_en)  idx <= '0;
        else if (scan_we) idx <= idx + 1'b1;
    end

    diag_snapshot u_snap (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en      (cap_en),
        .live_bytes  (live_bytes),
        .limit_bytes (limit_bytes),
        .live_w      (live_w),
        .limit_w     (limit_w)
    );

    diag_cmp u_cmp (
        .is_signed (SIGNED_MASK[idx]),
        .value     (live_w[idx]),
        .limits    (limit_w[idx]),
        .verdict   (verdict)
    );

    diag_flag_acc u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (scan_we),
        .idx     (idx),
        .verdict (verdict),
        .commit  (commit),
        .alarm_a (alarm_flags_a),
        .alarm_b (alarm_flags_b),
        .warn_a  (warn_flags_a),
        .warn_b  (warn_flags_b),
        .done    (flags_done)
    );

    assert_idx_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |-> (idx <= LAST_IDX));

    assert_scan_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && idx == LAST_IDX) |=> (state == ST_COMMIT));

    assert_busy_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && mon_strobe && !(state == ST_SCAN && idx == LAST_IDX))
            |=> (state != ST_IDLE || $past(state) == ST_COMMIT));

endmodule

// File: tb/diag_threshold_flagger_test.sv
module diag_threshold_flagger_test;

    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 6;

    typedef struct {
        logic [31:0] exp;
        int          t0;
        string       tag;
    } sb_item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mon_strobe = 1'b0;
    logic [79:0]  live_bytes = '0;
    logic [319:0] limit_bytes = '0;
    logic [7:0]   alarm_flags_a, alarm_flags_b, warn_flags_a, warn_flags_b;
    logic         flags_done;

    logic [15:0]  val [5];
    logic [15:0]  lim [5][4];
    sb_item_t     sbq [$];
    sb_item_t     cur;
    logic [31:0]  last_obs = '0;
    int           cyc = 0, checks = 0, errors = 0;
    int           n_push = 0, n_done = 0, stab_bad = 0;
    bit           finished = 0;

    diag_threshold_flagger uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mon_strobe    (mon_strobe),
        .live_bytes    (live_bytes),
        .limit_bytes   (limit_bytes),
        .alarm_flags_a (alarm_flags_a),
        .alarm_flags_b (alarm_flags_b),
        .warn_flags_a  (warn_flags_a),
        .warn_flags_b  (warn_flags_b),
        .flags_done    (flags_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected flags from the requirements (R2-R8)
    function automatic logic [31:0] model();
        logic [4:0] ah, al, wh, wl;
        for (int p = 0; p < 5; p++) begin
            if (p == 0) begin
                ah[p] = $signed(val[p]) > $signed(lim[p][0]);
                al[p] = $signed(val[p]) < $signed(lim[p][1]);
                wh[p] = $signed(val[p]) > $signed(lim[p][2]);
                wl[p] = $signed(val[p]) < $signed(lim[p][3]);
            end else begin
                ah[p] = val[p] > lim[p][0];
                al[p] = val[p] < lim[p][1];
                wh[p] = val[p] > lim[p][2];
                wl[p] = val[p] < lim[p][3];
            end
        end
        return {ah[0], al[0], ah[1], al[1], ah[2], al[2], ah[3], al[3], ah[4], al[4], 6'b0,
                wh[0], wl[0], wh[1], wl[1], wh[2], wl[2], wh[3], wl[3], wh[4], wl[4], 6'b0};
    endfunction

    // R9 byte placement
    task automatic pack_buses();
        for (int p = 0; p < 5; p++) begin
            live_bytes[16*p +: 8]   = val[p][15:8];
            live_bytes[16*p+8 +: 8] = val[p][7:0];
            for (int k = 0; k < 4; k++) begin
                limit_bytes[64*p+16*k +: 8]   = lim[p][k][15:8];
                limit_bytes[64*p+16*k+8 +: 8] = lim[p][k][7:0];
            end
        end
    endtask

    task automatic set_defaults();
        lim[0][0] = 16'h6E00; lim[0][1] = 16'hD300; lim[0][2] = 16'h5F00; lim[0][3] = 16'hD600;
        lim[1][0] = 16'd36000; lim[1][1] = 16'd28000; lim[1][2] = 16'd35000; lim[1][3] = 16'd30000;
        lim[2][0] = 16'd60000; lim[2][1] = 16'd5000;  lim[2][2] = 16'd55000; lim[2][3] = 16'd7500;
        lim[3][0] = 16'd1000;  lim[3][1] = 16'd50;    lim[3][2] = 16'd631;   lim[3][3] = 16'd63;
        lim[4][0] = 16'd1000;  lim[4][1] = 16'd5;     lim[4][2] = 16'd631;   lim[4][3] = 16'd6;
    endtask

    task automatic set_nominal();
        val[0] = 16'h1900; val[1] = 16'd33000; val[2] = 16'd30000;
        val[3] = 16'd200;  val[4] = 16'd200;
    endtask

    // driver: pulse strobe and push the expected result
    task automatic launch(input string tag);
        sb_item_t it;
        @(negedge clk);
        pack_buses();
        mon_strobe = 1'b1;
        @(posedge clk);
        #1;
        it.exp = model();
        it.t0  = cyc;
        it.tag = tag;
        sbq.push_back(it);
        n_push++;
        @(negedge clk);
        mon_strobe = 1'b0;
    endtask

    task automatic run(input string tag);
        launch(tag);
        repeat (LATENCY + 2) @(posedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (flags_done) begin
                n_done++;
                if (sbq.size() == 0) begin
                    chk(0, "R12 completion with nothing pending", 32'(n_done), 32'(n_push));
                end else begin
                    cur = sbq.pop_front();
                    chk({alarm_flags_a, alarm_flags_b, warn_flags_a, warn_flags_b} == cur.exp,
                        cur.tag, {alarm_flags_a, alarm_flags_b, warn_flags_a, warn_flags_b}, cur.exp);
                    chk(cyc == cur.t0 + LATENCY, "R11 completion latency",
                        32'(cyc - cur.t0), 32'(LATENCY));
                end
                last_obs = {alarm_flags_a, alarm_flags_b, warn_flags_a, warn_flags_b};
            end else if ({alarm_flags_a, alarm_flags_b, warn_flags_a, warn_flags_b} != last_obs) begin
                stab_bad++;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1;
            chk(0, "watchdog expired", 32'(cyc), 32'd20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        set_defaults();
        set_nominal();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({alarm_flags_a, alarm_flags_b, warn_flags_a, warn_flags_b, flags_done} == 33'b0,
            "R1 flags clear in reset", {alarm_flags_a, alarm_flags_b, warn_flags_a, warn_flags_b}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({alarm_flags_a, alarm_flags_b, warn_flags_a, warn_flags_b, flags_done} == 33'b0,
            "R1 flags clear after reset", {alarm_flags_a, alarm_flags_b, warn_flags_a, warn_flags_b}, 0);

        run("R2 R3 nominal readings");

        for (int p = 0; p < 5; p++) val[p] = lim[p][0];
        run("R2 readings equal high alarm limit");

        for (int p = 0; p < 5; p++) val[p] = lim[p][1];
        run("R3 readings equal low alarm limit");

        set_nominal();
        for (int p = 0; p < 4; p++) val[p] = lim[p][0] + 16'd1;
        run("R6 R2 high alarms in first byte");

        set_nominal();
        val[4] = 16'd4;
        run("R7 received power low alarm");

        set_nominal();
        val[0] = 16'h6400; val[2] = 16'd6000;
        run("R8 warning only");

        set_nominal();
        val[0] = 16'hFF00;
        run("R4 temperature -1C no flag");

        val[0] = 16'hD200;
        run("R4 temperature -46C low alarm");

        set_nominal();
        val[1] = 16'hFF00;
        run("R5 unsigned supply high");

        set_nominal();
        lim[1][0] = 16'h01FF; lim[1][2] = 16'h0100; val[1] = 16'h0180;
        lim[3][1] = 16'h0201; val[3] = 16'h0200;
        run("R9 MSB first byte order");
        set_defaults();

        // R10: inputs change mid-scan, result must follow the snapshot
        set_nominal();
        launch("R10 snapshot at strobe edge");
        @(negedge clk);
        for (int p = 0; p < 5; p++) val[p] = lim[p][0] + 16'd1;
        pack_buses();
        repeat (LATENCY + 2) @(posedge clk);

        // R12: strobe during a busy scan is dropped
        set_nominal();
        launch("R12 first strobe result");
        @(negedge clk);
        val[1] = 16'hFFFF;
        pack_buses();
        mon_strobe = 1'b1;
        @(negedge clk);
        mon_strobe = 1'b0;
        repeat (LATENCY + 6) @(posedge clk);
        @(negedge clk);
        chk(n_done == n_push && sbq.size() == 0, "R12 no extra completion",
            32'(n_done), 32'(n_push));

        chk(stab_bad == 0, "R11 flags held between completions", 32'(stab_bad), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule